// File: doc/BRIEF.md
# Flash Reprogramming Control Register

This block is a single-address, 8-bit control and status register that decides when the on-chip flash may be reprogrammed by the CPU. Software writes the register over a simple bus port and reads it back through a combinational read port. The block drives four control outputs: a reprogramming-mode enable, a lock-bypass enable, a one-cycle flash-circuit reset pulse and a boot/user ROM area select.

The mode enable and the lock-bypass enable are armed only by a two-write sequence: a write of 0 and then, as the very next write, a write of 1 to the same bit. The flash reset is issued by a write of 1 and then, as the very next write, a write of 0 to the reset bit. A mode state machine holds three states: `MODE_NORMAL` (mode off), `MODE_REPROG` (mode on, locks honoured) and `MODE_REPROG_NOLOCK` (mode on, locks bypassed). Its transitions are: `arm_mode` (NORMAL to REPROG), `arm_nolock` (REPROG to REPROG_NOLOCK), `drop_nolock` (REPROG_NOLOCK to REPROG) and `drop_mode` (either mode-on state to NORMAL, with priority over `arm_nolock`). Each two-write sequence is followed by a tracker with the states `SEQ_IDLE` and `SEQ_PRIMED`. A tracker goes to `step_prime` when the first value of its sequence is written, goes to `step_reset` on any other accepted write, and goes to `clear` on a break.

A ready bit follows the flash write state machine's busy flag, but only for commands that program or erase. A strap input says whether the part booted in boot mode. A gate input flags writes whose instruction was fetched from flash, and the block refuses those writes for the mode and reset bits.

Top module: `flash_reprog_ctl`

## Requirements
- R1: After reset the read port returns 8'h01, and reprog_en, lock_bypass and flash_rst are 0.
- R2: Bit 1 (mode enable) becomes 1 only when a register write carrying bit1=1 directly follows a register write carrying bit1=0. A lone write of 1 leaves it at 0. Any write to another address between the two writes breaks the sequence.
- R3: An accepted register write with bit1=0 clears bit 1, bit 2 and bit 3 at the next clock edge, even when the same write would complete the bit-2 arming sequence.
- R4: Bit 2 (lock bypass) uses the same 0-then-1 arming rule as bit 1. A write of 0 clears it. Writes to bit 2 are accepted only while bit 1 is 1 before the write.
- R5: Bit 3 holds the last accepted written value while bit 1 is 1 and reads 0 while bit 1 is 0. An accepted write of bit3=0 that directly follows an accepted write of bit3=1, made while bit 1 is 1, drives flash_rst high for exactly the next clock cycle. This happens even if the same write clears bit 1.
- R6: Bit 0 reads 1 from reset. It takes the value !wsm_busy one cycle after wsm_cmd carries a tracked code: 1 page program, 2 block erase, 3 erase all unlocked, 4 lock-bit program. For any other code it holds its value.
- R7: Bit 5 stores the written value at every register write. user_area_sel is 1 when boot_strap is 0, and equals bit 5 when boot_strap is 1.
- R8: Bits 7, 6 and 4 always read 0, whatever is written to them.
- R9: While fetch_gate is 1, a register write leaves bits 1 and 3 unchanged and breaks their pending sequences. Bits 2 and 5 of the same write are still accepted under their own rules.
- R10: reprog_en equals bit 1 and lock_bypass equals bit 2 of the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Register read value |
| fetch_gate | input | 1 | Writing instruction was fetched from flash |
| wsm_busy | input | 1 | Flash write state machine busy |
| wsm_cmd | input | 3 | Command code the write state machine is running |
| boot_strap | input | 1 | Part started in boot mode |
| reprog_en | output | 1 | Reprogramming mode enable |
| lock_bypass | output | 1 | Lock bits disregarded |
| flash_rst | output | 1 | One-cycle flash circuit reset |
| user_area_sel | output | 1 | 1 selects the user ROM area, 0 the boot ROM area |

## Verification
Two functions can fall on the same write. The first case is a write that clears bit 1 while it completes another sequence. The bench first primes the lock-bypass sequence and then writes bit1=0 with bit2=1; clearing must win, so the next read is 8'h01 with both enables low. The bench also primes the reset sequence and then writes bit1=0 with bit3=0; the mode must drop and flash_rst must still pulse for exactly one cycle. The second case is a gated write, where bit 2 must take its new value while bits 1 and 3 keep theirs.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    localparam int CMD_W = 3;

    localparam int POS_READY  = 0;
    localparam int POS_MODE   = 1;
    localparam int POS_NOLOCK = 2;
    localparam int POS_FRST   = 3;
    localparam int POS_AREA   = 5;

    localparam logic [CMD_W-1:0] CMD_PAGE_PROG      = 3'd1;
    localparam logic [CMD_W-1:0] CMD_BLOCK_ERASE    = 3'd2;
    localparam logic [CMD_W-1:0] CMD_ERASE_UNLOCKED = 3'd3;
    localparam logic [CMD_W-1:0] CMD_LOCK_PROG      = 3'd4;

    typedef enum logic [1:0] {
        MODE_NORMAL        = 2'd0,
        MODE_REPROG        = 2'd1,
        MODE_REPROG_NOLOCK = 2'd2
    } mode_e;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_PRIMED = 1'b1
    } seq_e;

    function automatic logic cmd_tracks_busy(input logic [CMD_W-1:0] c);
        return (c == CMD_PAGE_PROG) || (c == CMD_BLOCK_ERASE) ||
               (c == CMD_ERASE_UNLOCKED) || (c == CMD_LOCK_PROG);
    endfunction

endpackage

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker
    import flash_ctl_pkg::*;
#(
    parameter logic PRIME_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    input  logic bit_val,
    output logic fire
);

    seq_e state_q;
    seq_e state_d;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = SEQ_IDLE;
        end else if (step) begin
            unique case (state_q)
                SEQ_IDLE:   state_d = (bit_val == PRIME_VAL) ? SEQ_PRIMED : SEQ_IDLE;
                SEQ_PRIMED: state_d = (bit_val == PRIME_VAL) ? SEQ_PRIMED : SEQ_IDLE;
                default:    state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fire = (state_q == SEQ_PRIMED) && step && !clear && (bit_val != PRIME_VAL);
    end

endmodule

// File: rtl/flash_ready_track.sv
module flash_ready_track
    import flash_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wsm_busy,
    input  logic [CMD_W-1:0] wsm_cmd,
    output logic             ready
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready <= 1'b1;
        end else if (cmd_tracks_busy(wsm_cmd)) begin
            ready <= !wsm_busy;
        end
    end

endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
    import flash_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arm_mode,
    input  logic  drop_mode,
    input  logic  arm_nolock,
    input  logic  drop_nolock,
    output mode_e mode
);

    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL: begin
                if (arm_mode) mode_d = MODE_REPROG;
            end
            MODE_REPROG: begin
                if (drop_mode)       mode_d = MODE_NORMAL;
                else if (arm_nolock) mode_d = MODE_REPROG_NOLOCK;
            end
            MODE_REPROG_NOLOCK: begin
                if (drop_mode)        mode_d = MODE_NORMAL;
                else if (drop_nolock) mode_d = MODE_REPROG;
            end
            default: mode_d = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/flash_reprog_ctl.sv
module flash_reprog_ctl
    import flash_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              fetch_gate,
    input  logic              wsm_busy,
    input  logic [2:0]        wsm_cmd,
    input  logic              boot_strap,
    output logic              reprog_en,
    output logic              lock_bypass,
    output logic              flash_rst,
    output logic              user_area_sel
);

    logic  hit_wr, other_wr, key_wr, dep_wr, gated_wr;
    logic  mode_on;
    logic  arm_mode, arm_nolock, rst_fire;
    logic  drop_mode, drop_nolock;
    logic  ready;
    logic  frst_q, area_q, pulse_q;
    mode_e mode;
    logic  unused_wbits;

    assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[4], bus_wdata[0]};

    // write qualification
    always_comb begin
        hit_wr      = bus_wr && (bus_addr == REG_ADDR);
        other_wr    = bus_wr && (bus_addr != REG_ADDR);
        gated_wr    = hit_wr && fetch_gate;
        key_wr      = hit_wr && !fetch_gate;
        mode_on     = (mode != MODE_NORMAL);
        dep_wr      = hit_wr && mode_on;
        drop_mode   = key_wr && !bus_wdata[POS_MODE];
        drop_nolock = dep_wr && !bus_wdata[POS_NOLOCK];
    end

    flash_seq_tracker #(.PRIME_VAL(1'b0)) u_seq_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (key_wr),
        .clear   (other_wr || gated_wr),
        .bit_val (bus_wdata[POS_MODE]),
        .fire    (arm_mode)
    );

    flash_seq_tracker #(.PRIME_VAL(1'b0)) u_seq_nolock (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (dep_wr),
        .clear   (other_wr || !mode_on),
        .bit_val (bus_wdata[POS_NOLOCK]),
        .fire    (arm_nolock)
    );

    flash_seq_tracker #(.PRIME_VAL(1'b1)) u_seq_frst (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (key_wr && mode_on),
        .clear   (other_wr || gated_wr || !mode_on),
        .bit_val (bus_wdata[POS_FRST]),
        .fire    (rst_fire)
    );

    flash_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_mode    (arm_mode),
        .drop_mode   (drop_mode),
        .arm_nolock  (arm_nolock),
        .drop_nolock (drop_nolock),
        .mode        (mode)
    );

    flash_ready_track u_ready (
        .clk      (clk),
        .rst_n    (rst_n),
        .wsm_busy (wsm_busy),
        .wsm_cmd  (wsm_cmd),
        .ready    (ready)
    );

    // stored bits: reset bit, area bit, reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frst_q  <= 1'b0;
            area_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= rst_fire;
            if (!mode_on || drop_mode) frst_q <= 1'b0;
            else if (key_wr)           frst_q <= bus_wdata[POS_FRST];
            if (hit_wr) area_q <= bus_wdata[POS_AREA];
        end
    end

    // outputs
    always_comb begin
        bus_rdata             = 8'h00;
        bus_rdata[POS_READY]  = ready;
        bus_rdata[POS_MODE]   = mode_on;
        bus_rdata[POS_NOLOCK] = (mode == MODE_REPROG_NOLOCK);
        bus_rdata[POS_FRST]   = frst_q;
        bus_rdata[POS_AREA]   = area_q;
        reprog_en             = mode_on;
        lock_bypass           = (mode == MODE_REPROG_NOLOCK);
        flash_rst             = pulse_q;
        user_area_sel         = !boot_strap || area_q;
    end

endmodule

module flash_reprog_ctl_chk
    import flash_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              fetch_gate,
    input logic [2:0]        wsm_cmd,
    input logic              boot_strap,
    input logic              reprog_en,
    input logic              lock_bypass,
    input logic              flash_rst,
    input logic              user_area_sel
);

    a_r2_arm_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reprog_en) |-> $past(bus_wr && bus_addr == REG_ADDR && bus_wdata[1] && !fetch_gate));

    a_r3_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR && !fetch_gate && !bus_wdata[1])
        |=> (!reprog_en && !lock_bypass && !bus_rdata[3]));

    a_r4_bypass_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        lock_bypass |-> reprog_en);

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rst |=> !flash_rst);

    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rst |-> $past(bus_wr && bus_addr == REG_ADDR && !bus_wdata[3] && !fetch_gate));

    a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_tracks_busy(wsm_cmd) |=> $stable(bus_rdata[0]));

    a_r7_user_outside_boot: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_strap |-> user_area_sel);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:6] == 2'b00) && !bus_rdata[4]);

    a_r9_gate_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR && fetch_gate && !reprog_en) |=> !reprog_en);

endmodule

bind flash_reprog_ctl flash_reprog_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .fetch_gate    (fetch_gate),
    .wsm_cmd       (wsm_cmd),
    .boot_strap    (boot_strap),
    .reprog_en     (reprog_en),
    .lock_bypass   (lock_bypass),
    .flash_rst     (flash_rst),
    .user_area_sel (user_area_sel)
);

// File: tb/flash_reprog_ctl_test.sv
module flash_reprog_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       fetch_gate = 1'b0;
    logic       wsm_busy = 1'b0;
    logic [2:0] wsm_cmd = 3'd0;
    logic       boot_strap = 1'b1;
    logic       reprog_en, lock_bypass, flash_rst, user_area_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic [3:0] outs;   // {reprog_en, lock_bypass, flash_rst, user_area_sel}
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    flash_reprog_ctl #(.ADDR_W(8), .REG_ADDR(8'h40)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .fetch_gate    (fetch_gate),
        .wsm_busy      (wsm_busy),
        .wsm_cmd       (wsm_cmd),
        .boot_strap    (boot_strap),
        .reprog_en     (reprog_en),
        .lock_bypass   (lock_bypass),
        .flash_rst     (flash_rst),
        .user_area_sel (user_area_sel)
    );

    // monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            logic [3:0] got;
            e = sb.pop_front();
            got = {reprog_en, lock_bypass, flash_rst, user_area_sel};
            checks++;
            if (bus_rdata !== e.rd || got !== e.outs) begin
                errors++;
                $display("FAIL %s rdata=%h outs=%b expected rdata=%h outs=%b",
                         e.tag, bus_rdata, got, e.rd, e.outs);
            end
        end
    end

    // driver: one cycle of stimulus, expectation for after the next edge
    task automatic op(input bit wr, input logic [7:0] a, input logic [7:0] d,
                      input bit gate, input logic [2:0] cmd, input bit busy,
                      input bit strap, input logic [7:0] exp_rd,
                      input logic [3:0] exp_out, input string tag);
        exp_t e;
        @(negedge clk);
        bus_wr     = wr;
        bus_addr   = a;
        bus_wdata  = d;
        fetch_gate = gate;
        wsm_cmd    = cmd;
        wsm_busy   = busy;
        boot_strap = strap;
        e.rd = exp_rd;
        e.outs = exp_out;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr40(input logic [7:0] d, input logic [7:0] exp_rd,
                        input logic [3:0] exp_out, input string tag);
        op(1'b1, 8'h40, d, 1'b0, 3'd0, 1'b0, 1'b1, exp_rd, exp_out, tag);
    endtask

    task automatic gwr40(input logic [7:0] d, input logic [7:0] exp_rd,
                         input logic [3:0] exp_out, input string tag);
        op(1'b1, 8'h40, d, 1'b1, 3'd0, 1'b0, 1'b1, exp_rd, exp_out, tag);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        op(1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h01, 4'b0001, "R7 strap low gives user area");
        op(1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h01, 4'b0000, "R1 reset state");
        wr40(8'h02, 8'h01, 4'b0000, "R2 lone one ignored");
        wr40(8'h00, 8'h01, 4'b0000, "R2 primer");
        wr40(8'h02, 8'h03, 4'b1000, "R2 armed");
        wr40(8'h00, 8'h01, 4'b0000, "R3 clear");
        wr40(8'h00, 8'h01, 4'b0000, "R2 primer again");
        op(1'b1, 8'h41, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h01, 4'b0000, "R2 foreign write");
        wr40(8'h02, 8'h01, 4'b0000, "R2 broken sequence");
        wr40(8'h04, 8'h01, 4'b0000, "R4 bit2 ignored while off");
        wr40(8'h08, 8'h01, 4'b0000, "R5 bit3 forced zero while off");
        wr40(8'h02, 8'h03, 4'b1000, "R10 armed mirrors");
        wr40(8'h06, 8'h03, 4'b1000, "R4 lone one ignored");
        wr40(8'h02, 8'h03, 4'b1000, "R4 primer");
        wr40(8'h06, 8'h07, 4'b1100, "R4 armed");
        wr40(8'h0E, 8'h0F, 4'b1100, "R5 bit3 stored");
        wr40(8'h06, 8'h07, 4'b1110, "R5 reset pulse");
        op(1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h07, 4'b1100, "R5 pulse single cycle");
        wr40(8'h26, 8'h27, 4'b1101, "R7 user area");
        wr40(8'hD6, 8'h07, 4'b1100, "R8 reserved bits read zero");
        op(1'b0, 8'h00, 8'h00, 1'b0, 3'd1, 1'b1, 1'b1, 8'h06, 4'b1100, "R6 busy tracked");
        op(1'b0, 8'h00, 8'h00, 1'b0, 3'd5, 1'b0, 1'b1, 8'h06, 4'b1100, "R6 untracked holds");
        op(1'b0, 8'h00, 8'h00, 1'b0, 3'd2, 1'b0, 1'b1, 8'h07, 4'b1100, "R6 ready again");
        gwr40(8'h00, 8'h03, 4'b1000, "R9 gated keeps bit1 writes bit2");
        wr40(8'h0E, 8'h0F, 4'b1100, "R4 rearm and R5 prime");
        gwr40(8'h06, 8'h0F, 4'b1100, "R9 gated keeps bit3");
        wr40(8'h06, 8'h07, 4'b1100, "R9 gated write broke reset sequence");
        wr40(8'h0E, 8'h0F, 4'b1100, "R5 prime");
        wr40(8'h00, 8'h01, 4'b0010, "R3 clear with coincident reset pulse");
        wr40(8'h00, 8'h01, 4'b0000, "R2 primer");
        wr40(8'h02, 8'h03, 4'b1000, "R2 armed");
        wr40(8'h02, 8'h03, 4'b1000, "R4 primer");
        wr40(8'h04, 8'h01, 4'b0000, "R3 clear wins over bit2 arm");
        gwr40(8'h00, 8'h01, 4'b0000, "R9 gated primer");
        wr40(8'h02, 8'h01, 4'b0000, "R9 gated primer does not arm");
        gwr40(8'h20, 8'h21, 4'b0001, "R9 gated bit5 accepted");
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule